// File: doc/BRIEF.md
# Serial Control Port Slave for a Two-Channel Volume Controller

This block is the control-side front end of a stereo gain stage. A host reaches it over three wires: an active-low select, a serial clock, and one data line that the host and the block take turns to drive. Every transaction is 16 serial clocks long. The first byte names a function and a direction. The second byte carries data, either from the host to the block or from the block to the host. The block holds the left and right gain codes, the peak-detector reference and a test byte. For a write that changes a gain, it sends a one-cycle load request to the gain-update controller that sits after it. It also reads back two pairs of status bits from that controller.

The serial clock, the select and the incoming data are all synchronized into the system clock. Edges are detected on the synchronized copies, so the serial clock never clocks any flop. The data pin is split into an input, an output and an output enable, which the pad ring joins. Load requests are plain pulses and cannot be held back; the controller that receives them must take each one in the cycle it appears.

Top module: `vctl_serial_slave`

## Requirements
- R1: After reset, the left gain, right gain and test byte read 00h, the peak reference reads FFh, the load strobe is low and the data output enable is low.
- R2: A frame is 16 rising serial-clock edges while the select is low. The first byte is the address and the second byte is the data, each MSB first and sampled on rising edges. A write takes effect only after the 16th rising edge.
- R3: In the address byte, bit 2 chooses the direction (1 = read, 0 = write), bits 7, 1 and 0 are ignored, and bits 6..3 choose the function. The write codes are: 1100 peak reference, 1101 left gain, 1110 right gain, 1111 test byte, 1001 both gains.
- R4: Function codes 0101, 0110 and 0111 write the left gain, the right gain, or both, as instant loads. The values go into the same gain registers that the ordinary gain reads return.
- R5: Each gain-changing write raises the load strobe for exactly one system clock. Its flags say which of left and right are loaded and whether the load is instant (set only for codes 01xx). Writes that change no gain produce no strobe.
- R6: On a read, the block drives the first data bit after the falling edge that follows the 8th rising edge. It moves to the next bit on each later falling edge, MSB first. Codes 1100, 1101, 1110 and 1111 return the stored byte. Code 1010 returns {000000, write-busy[1:0]} and code 1011 returns {000000, peak[1:0]}, where bit 1 is left and bit 0 is right.
- R7: The data output enable is low whenever the select is high. A read of a code outside the six readable codes never enables the output.
- R8: If the select rises before the 16th rising edge, the partial frame is dropped: no register changes and no strobe is raised.
- R9: A write to the status codes (1010, 1011) or to an unassigned code changes no register and raises no strobe.
- R10: Frames work the same whether the serial clock rests high or low between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from host |
| csn_i | input | 1 | Active-low frame select |
| sdat_i | input | 1 | Serial data from the pad |
| sdat_o | output | 1 | Serial read data to the pad |
| sdat_oe | output | 1 | Pad output enable for read data |
| busy_i | input | 2 | Write-busy status {left,right} from gain controller |
| peak_i | input | 2 | Peak status {left,right} from gain controller |
| gain_left_o | output | 8 | Stored left gain code |
| gain_right_o | output | 8 | Stored right gain code |
| peak_ref_o | output | 8 | Stored peak-detector reference |
| test_o | output | 8 | Stored test byte |
| ld_valid_o | output | 1 | One-cycle gain load request |
| ld_left_o | output | 1 | Load request includes left channel |
| ld_right_o | output | 1 | Load request includes right channel |
| ld_instant_o | output | 1 | Load request skips the zero-cross wait |

## Verification
The checks assume each serial-clock half period lasts longer than the synchronizer and edge-detect delay, about four system clocks. They also assume the select stays high long enough to be seen before the next frame begins. This is why read drive can only begin while the serial clock is still low. The bench holds every serial half period at six system clocks and holds every gap between frames at several half periods. It changes pad inputs only on the falling system-clock edge. Frames are run with both resting levels of the serial clock, cut short, and aimed at read-only and unassigned codes.

// File: rtl/vctl_pkg.sv
package vctl_pkg;

  typedef enum logic [3:0] {
    FN_WSTAT  = 4'b1010,
    FN_PSTAT  = 4'b1011,
    FN_PREF   = 4'b1100,
    FN_LEFT   = 4'b1101,
    FN_RIGHT  = 4'b1110,
    FN_TEST   = 4'b1111,
    FN_BOTH   = 4'b1001,
    FN_ILEFT  = 4'b0101,
    FN_IRIGHT = 4'b0110,
    FN_IBOTH  = 4'b0111
  } fn_e;

  typedef struct packed {
    logic pref;
    logic left;
    logic right;
    logic test;
    logic instant;
  } wr_ctl_t;

  function automatic wr_ctl_t decode_wr(input logic [3:0] fn);
    wr_ctl_t c;
    c = '0;
    case (fn)
      FN_PREF:   c.pref = 1'b1;
      FN_LEFT:   c.left = 1'b1;
      FN_RIGHT:  c.right = 1'b1;
      FN_TEST:   c.test = 1'b1;
      FN_BOTH:   begin c.left = 1'b1; c.right = 1'b1; end
      FN_ILEFT:  begin c.left = 1'b1; c.instant = 1'b1; end
      FN_IRIGHT: begin c.right = 1'b1; c.instant = 1'b1; end
      FN_IBOTH:  begin c.left = 1'b1; c.right = 1'b1; c.instant = 1'b1; end
      default:   c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/vctl_sync.sv
module vctl_sync #(
  parameter int   STAGES = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/vctl_frame.sv
module vctl_frame #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  localparam int FRAME = ADDR_W + DATA_W,
  localparam int CNT_W = $clog2(FRAME + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              csn_s,
  input  logic              sdat_s,
  input  logic              rd_ok,
  input  logic [DATA_W-1:0] rd_byte,
  output logic [FRAME-1:0]  shreg,
  output logic [CNT_W-1:0]  cnt,
  output logic              done,
  output logic              tx_bit,
  output logic              tx_en
);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(FRAME - 1);
  localparam logic [CNT_W-1:0] FULL   = CNT_W'(FRAME);
  localparam logic [CNT_W-1:0] AD_END = CNT_W'(ADDR_W);

  logic              sclk_d;
  logic              rise, fall;
  logic [DATA_W-1:0] tx;

  assign rise   = sclk_s & ~sclk_d;
  assign fall   = ~sclk_s & sclk_d;
  assign tx_bit = tx[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      shreg  <= '0;
      cnt    <= '0;
      done   <= 1'b0;
      tx     <= '0;
      tx_en  <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      done   <= 1'b0;
      if (csn_s) begin
        cnt   <= '0;
        tx_en <= 1'b0;
      end else begin
        if (rise && cnt != FULL) begin
          shreg <= {shreg[FRAME-2:0], sdat_s};
          cnt   <= cnt + 1'b1;
          if (cnt == LAST) done <= 1'b1;
        end
        if (fall && cnt == AD_END && rd_ok) begin
          tx    <= rd_byte;
          tx_en <= 1'b1;
        end else if (fall && tx_en && cnt > AD_END) begin
          tx <= {tx[DATA_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/vctl_regs.sv
module vctl_regs
  import vctl_pkg::*;
#(
  parameter int              DATA_W   = 8,
  parameter int              ST_W     = 2,
  parameter logic [DATA_W-1:0] PREF_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [3:0]        wr_fn,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [3:0]        rd_fn,
  input  logic              rd_dir,
  input  logic [ST_W-1:0]   busy_i,
  input  logic [ST_W-1:0]   peak_i,
  output logic              rd_ok,
  output logic [DATA_W-1:0] rd_byte,
  output logic [DATA_W-1:0] gain_l,
  output logic [DATA_W-1:0] gain_r,
  output logic [DATA_W-1:0] pref,
  output logic [DATA_W-1:0] test,
  output logic              ld_valid,
  output logic              ld_left,
  output logic              ld_right,
  output logic              ld_instant
);
  wr_ctl_t wc;
  assign wc = decode_wr(wr_fn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_l     <= '0;
      gain_r     <= '0;
      pref       <= PREF_RST;
      test       <= '0;
      ld_valid   <= 1'b0;
      ld_left    <= 1'b0;
      ld_right   <= 1'b0;
      ld_instant <= 1'b0;
    end else begin
      ld_valid <= commit & (wc.left | wc.right);
      if (commit) begin
        ld_left    <= wc.left;
        ld_right   <= wc.right;
        ld_instant <= wc.instant;
        if (wc.left)  gain_l <= wr_data;
        if (wc.right) gain_r <= wr_data;
        if (wc.pref)  pref   <= wr_data;
        if (wc.test)  test   <= wr_data;
      end
    end
  end

  always_comb begin
    rd_ok   = rd_dir;
    rd_byte = '0;
    case (rd_fn)
      FN_WSTAT: rd_byte = {{(DATA_W-ST_W){1'b0}}, busy_i};
      FN_PSTAT: rd_byte = {{(DATA_W-ST_W){1'b0}}, peak_i};
      FN_PREF:  rd_byte = pref;
      FN_LEFT:  rd_byte = gain_l;
      FN_RIGHT: rd_byte = gain_r;
      FN_TEST:  rd_byte = test;
      default:  rd_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/vctl_serial_slave.sv
module vctl_serial_slave #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int SYNC_LEN = 2,
  parameter int ST_W     = 2,
  localparam int FRAME   = ADDR_W + DATA_W,
  localparam int CNT_W   = $clog2(FRAME + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              sdat_i,
  output logic              sdat_o,
  output logic              sdat_oe,
  input  logic [ST_W-1:0]   busy_i,
  input  logic [ST_W-1:0]   peak_i,
  output logic [DATA_W-1:0] gain_left_o,
  output logic [DATA_W-1:0] gain_right_o,
  output logic [DATA_W-1:0] peak_ref_o,
  output logic [DATA_W-1:0] test_o,
  output logic              ld_valid_o,
  output logic              ld_left_o,
  output logic              ld_right_o,
  output logic              ld_instant_o
);
  logic              sclk_s, csn_s, sdat_s;
  logic [FRAME-1:0]  shreg;
  logic [CNT_W-1:0]  frame_cnt;
  logic              done, tx_en, rd_ok;
  logic [DATA_W-1:0] rd_byte;
  logic [ADDR_W-1:0] addr_full, addr_live;
  logic              commit;

  vctl_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b0)) u_sync_clk (
    .clk(clk), .rst_n(rst_n), .d(sclk_i), .q(sclk_s));
  vctl_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .d(csn_i), .q(csn_s));
  vctl_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b0)) u_sync_dat (
    .clk(clk), .rst_n(rst_n), .d(sdat_i), .q(sdat_s));

  vctl_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .csn_s(csn_s),
    .sdat_s(sdat_s), .rd_ok(rd_ok), .rd_byte(rd_byte),
    .shreg(shreg), .cnt(frame_cnt), .done(done),
    .tx_bit(sdat_o), .tx_en(tx_en));

  assign addr_full = shreg[FRAME-1:DATA_W];
  assign addr_live = shreg[ADDR_W-1:0];
  assign commit    = done & ~addr_full[2];

  vctl_regs #(.DATA_W(DATA_W), .ST_W(ST_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .commit(commit),
    .wr_fn(addr_full[6:3]), .wr_data(shreg[DATA_W-1:0]),
    .rd_fn(addr_live[6:3]), .rd_dir(addr_live[2]),
    .busy_i(busy_i), .peak_i(peak_i),
    .rd_ok(rd_ok), .rd_byte(rd_byte),
    .gain_l(gain_left_o), .gain_r(gain_right_o),
    .pref(peak_ref_o), .test(test_o),
    .ld_valid(ld_valid_o), .ld_left(ld_left_o),
    .ld_right(ld_right_o), .ld_instant(ld_instant_o));

  assign sdat_oe = tx_en & ~csn_i;
endmodule

// File: rtl/vctl_serial_chk.sv
module vctl_serial_chk #(
  parameter int CNT_W  = 5,
  parameter int DATA_W = 8,
  parameter int FRAME  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk_i,
  input logic              sdat_oe,
  input logic              ld_valid_o,
  input logic              ld_left_o,
  input logic              ld_right_o,
  input logic [DATA_W-1:0] gain_left_o,
  input logic [DATA_W-1:0] gain_right_o,
  input logic [CNT_W-1:0]  frame_cnt
);
  p_strobe_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid_o |=> !ld_valid_o);

  p_strobe_names_channel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid_o |-> (ld_left_o || ld_right_o));

  p_strobe_after_full_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid_o |-> (frame_cnt == CNT_W'(FRAME)));

  p_left_change_loaded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gain_left_o) |-> (ld_valid_o && ld_left_o));

  p_right_change_loaded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gain_right_o) |-> (ld_valid_o && ld_right_o));

  p_drive_starts_clock_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdat_oe) |-> !sclk_i);
endmodule

bind vctl_serial_slave vctl_serial_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W), .FRAME(FRAME)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sdat_oe(sdat_oe),
  .ld_valid_o(ld_valid_o), .ld_left_o(ld_left_o), .ld_right_o(ld_right_o),
  .gain_left_o(gain_left_o), .gain_right_o(gain_right_o),
  .frame_cnt(frame_cnt));

// File: tb/test_vctl_serial_slave.sv
module test_vctl_serial_slave;
  localparam int H = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, csn = 1'b1, sdi = 1'b0;
  logic       sdo, sdoe;
  logic [1:0] busy = 2'b00, peak = 2'b00;
  logic [7:0] gl, gr, pref, tst;
  logic       ldv, ldl, ldr, ldi;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic l; logic r; logic inst; logic [7:0] gl; logic [7:0] gr;
  } ld_item_t;
  ld_item_t exp_q[$];
  logic [7:0] m_gl = 8'h00, m_gr = 8'h00;

  always #4 clk = ~clk;

  vctl_serial_slave i_vctl_serial_slave (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .sdat_i(sdi),
    .sdat_o(sdo), .sdat_oe(sdoe), .busy_i(busy), .peak_i(peak),
    .gain_left_o(gl), .gain_right_o(gr), .peak_ref_o(pref), .test_o(tst),
    .ld_valid_o(ldv), .ld_left_o(ldl), .ld_right_o(ldr), .ld_instant_o(ldi));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor for load strobes (R5)
  always @(negedge clk) begin
    if (rst_n && ldv) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R5 unexpected strobe actual=%b%b%b expected=none", ldl, ldr, ldi);
      end else begin
        ld_item_t e;
        e = exp_q.pop_front();
        if ({ldl, ldr, ldi, gl, gr} !== {e.l, e.r, e.inst, e.gl, e.gr}) begin
          errors++;
          $display("FAIL R5 strobe actual=%h expected=%h", {ldl, ldr, ldi, gl, gr}, e);
        end
      end
    end
  end

  task automatic frame(input logic [7:0] a, input logic [7:0] d, input int nrise,
                       input bit idle_hi, output logic [7:0] rd,
                       output bit oe_all, output bit oe_any);
    logic [15:0] bits;
    bits = {a, d};
    rd = '0; oe_all = 1'b1; oe_any = 1'b0;
    sclk = idle_hi; tick(H);
    csn = 1'b0; tick(H);
    for (int i = 0; i < nrise; i++) begin
      sclk = 1'b0;
      sdi  = (i < 8 || !a[2]) ? bits[15-i] : 1'b0;
      tick(H);
      if (i >= 8) begin
        rd = {rd[6:0], sdo};
        oe_all &= sdoe;
        oe_any |= sdoe;
      end
      sclk = 1'b1;
      tick(H);
    end
    if (!idle_hi) begin sclk = 1'b0; end
    tick(H);
    csn = 1'b1;
    tick(1);
    chk("R7 oe off when deselected", sdoe, 1'b0);
    tick(4*H);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit idle_hi);
    logic [7:0] rd; bit x, y;
    logic [3:0] fn;
    fn = a[6:3];
    case (fn)
      4'b1101, 4'b0101: m_gl = d;
      4'b1110, 4'b0110: m_gr = d;
      4'b1001, 4'b0111: begin m_gl = d; m_gr = d; end
      default: ;
    endcase
    case (fn)
      4'b1101: exp_q.push_back('{1'b1, 1'b0, 1'b0, m_gl, m_gr});
      4'b1110: exp_q.push_back('{1'b0, 1'b1, 1'b0, m_gl, m_gr});
      4'b1001: exp_q.push_back('{1'b1, 1'b1, 1'b0, m_gl, m_gr});
      4'b0101: exp_q.push_back('{1'b1, 1'b0, 1'b1, m_gl, m_gr});
      4'b0110: exp_q.push_back('{1'b0, 1'b1, 1'b1, m_gl, m_gr});
      4'b0111: exp_q.push_back('{1'b1, 1'b1, 1'b1, m_gl, m_gr});
      default: ;
    endcase
    frame(a, d, 16, idle_hi, rd, x, y);
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [7:0] exp,
                       input bit idle_hi);
    logic [7:0] rd; bit all, any;
    frame(a, 8'h00, 16, idle_hi, rd, all, any);
    chk(req, rd, exp);
    chk("R6 output enabled for whole data byte", all, 1'b1);
  endtask

  initial begin
    logic [7:0] rd; bit all, any;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    // R1 reset state
    chk("R1 left gain", gl, 8'h00);
    chk("R1 right gain", gr, 8'h00);
    chk("R1 peak ref", pref, 8'hFF);
    chk("R1 test", tst, 8'h00);
    chk("R1 oe", sdoe, 1'b0);
    chk("R1 strobe", ldv, 1'b0);
    rdchk("R1 R6 peak ref read FF", 8'h64, 8'hFF, 0);

    // R2 R3: left write with ignored bits set, then read back
    wr(8'hEB, 8'h5A, 0);
    chk("R2 R3 left gain port", gl, 8'h5A);
    rdchk("R6 left read", 8'h6C, 8'h5A, 0);
    wr(8'h70, 8'hC3, 0);
    chk("R3 right gain port", gr, 8'hC3);
    rdchk("R6 right read", 8'hF4, 8'hC3, 0);
    wr(8'h4B, 8'h81, 0);
    chk("R3 both left", gl, 8'h81);
    chk("R3 both right", gr, 8'h81);

    // R4 instant variants
    wr(8'h28, 8'h22, 0);
    rdchk("R4 instant left readback", 8'h6C, 8'h22, 0);
    wr(8'h33, 8'h33, 0);
    rdchk("R4 instant right readback", 8'hF4, 8'h33, 0);
    wr(8'h38, 8'h44, 0);
    chk("R4 instant both left", gl, 8'h44);
    chk("R4 instant both right", gr, 8'h44);

    // R3 peak ref and test, no strobe
    wr(8'h60, 8'h10, 0);
    chk("R3 peak ref port", pref, 8'h10);
    rdchk("R6 peak ref read", 8'h64, 8'h10, 0);
    wr(8'h78, 8'h07, 0);
    rdchk("R6 test read", 8'h7C, 8'h07, 0);

    // R6 status reads
    busy = 2'b10; peak = 2'b01;
    rdchk("R6 write-status read", 8'h54, 8'h02, 0);
    rdchk("R6 peak-status read", 8'h5C, 8'h01, 0);

    // R9 write to status and unassigned codes ignored
    wr(8'h50, 8'hFF, 0);
    wr(8'h00, 8'hEE, 0);
    chk("R9 left unchanged", gl, 8'h44);
    chk("R9 right unchanged", gr, 8'h44);
    chk("R9 peak ref unchanged", pref, 8'h10);
    chk("R9 test unchanged", tst, 8'h07);

    // R8 partial frame dropped
    frame(8'h68, 8'h99, 12, 0, rd, all, any);
    chk("R8 left unchanged after short frame", gl, 8'h44);
    rdchk("R8 left read after short frame", 8'h6C, 8'h44, 0);

    // R7 unreadable read never drives
    frame(8'h4C, 8'h00, 16, 0, rd, all, any);
    chk("R7 no drive for unreadable code", any, 1'b0);

    // R10 clock resting high
    wr(8'h70, 8'h3C, 1);
    chk("R10 right gain idle-high", gr, 8'h3C);
    rdchk("R10 right read idle-high", 8'hF4, 8'h3C, 1);

    tick(10);
    chk("R5 all strobes seen", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule